// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block decides which microinstruction a microcoded execution unit runs next. Each cycle it reads the 32-bit microinstruction fetched from the current address. It also reads the opcode byte being executed, an 8-bit value returned by the bus unit, and a flag that says whether the last ALU result was zero. From these it registers the next 13-bit microcode address. Most microinstructions simply step to the following address. Jump microinstructions can redirect the sequence in several ways:
- to an address carried in the instruction itself;
- to an address built from the opcode byte, for dispatch on the opcode;
- to an address built from the low bits of the bus value, for a small bit-mask lookup table;
- back to an address saved by an earlier call.

A single return register gives one level of subroutine call. A jump flagged as a call stores the address after the call. A later jump through the return source comes back to that address. The flag input is expected to change only on non-jump microinstructions, so a jump always tests the result of the last real ALU step.

Top module: `useq_seq`

## Requirements
- R1: When `uinstr[31:28]` is not 4'h1, the next `uAddr` is the current `uAddr` plus one, wrapping from 13'h1FFF to 13'h0000.
- R2: A microinstruction is a jump only when `uinstr[31:28]` equals 4'h1. The condition code in `uinstr[19:16]` and the source code in `uinstr[22:20]` decide whether the jump is taken and where it goes.
- R3: Condition code 0 always takes the jump. Code 1 takes it when `aluZero` is 0. Code 2 takes it when `aluZero` is 1. Codes 3 to 15 never take it, and the address advances by one.
- R4: Source 0 jumps to `uinstr[12:0]`. Source 1 jumps to `opcodeByte` with zeros above it. Source 2 jumps to `{uinstr[12:4], opcodeByte[3:0]}`.
- R5: Source 4 jumps to `busRetData[2:0]` with zeros above it.
- R6: Source 3 jumps to the address held in the return register, shown on `retAddr`.
- R7: A taken jump with `uinstr[27:24]` nonzero loads the return register with the calling address plus one. It overwrites any earlier entry. When source 3 is combined with the call flag, the jump uses the old value. A jump that is not taken, and every non-jump, leaves the return register unchanged.
- R8: Source codes 5 to 7 count as not taken. The address advances by one and the return register is unchanged, even when the call flag is set.
- R9: While `rstN` is low at a rising clock edge, `uAddr` and `retAddr` become 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| uinstr | input | 32 | Microinstruction fetched from the current address |
| opcodeByte | input | 8 | Opcode byte under execution |
| busRetData | input | 8 | Data returned by the bus unit |
| aluZero | input | 1 | 1 when the last ALU result was zero |
| uAddr | output | 13 | Current microcode address (registered) |
| retAddr | output | 13 | Content of the return register |

## Verification
The bench targets the corner cases where a wrong decode looks plausible:
- A condition code outside 0 to 2 must fall through. A design that treated it as "always" would jump away.
- A call whose condition fails must leave the return register alone. A design that saved on every call flag would lose the earlier return point.
- A call that also returns through source 3 must jump to the old entry. A design that forwarded the new value would loop back to the address right after the call.
- The mixed opcode source must keep immediate bits [12:4]. A design that shifted the immediate would land on an unrelated address.
- Stepping past 13'h1FFF must wrap to 0. Reset asserted in the middle of a call must win over that call.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int ADDR_W = 13;
  localparam int OPC_W = 8;
  localparam int RET_W = 8;
  localparam int BITSEL_W = 3;
  localparam int NIB_W = 4;

  localparam logic [3:0] JUMP_CLASS = 4'h1;

  localparam logic [2:0] SRC_IMM = 3'd0;
  localparam logic [2:0] SRC_OPC = 3'd1;
  localparam logic [2:0] SRC_MIX = 3'd2;
  localparam logic [2:0] SRC_RET = 3'd3;
  localparam logic [2:0] SRC_BIT = 3'd4;

  localparam logic [3:0] COND_ALWAYS = 4'd0;
  localparam logic [3:0] COND_NONZERO = 4'd1;
  localparam logic [3:0] COND_ZERO = 4'd2;

  typedef struct packed {
    logic       take;
    logic       save;
    logic [2:0] src;
  } seqCtl_t;
endpackage

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic [3:0] classCode,
  input  logic [3:0] callCode,
  input  logic [2:0] srcCode,
  input  logic [3:0] condCode,
  input  logic       aluZero,
  output seqCtl_t    ctl
);
  logic isJump;
  logic condOk;
  logic srcOk;

  always_comb begin
    isJump = (classCode == JUMP_CLASS);
    case (condCode)
      COND_ALWAYS:  condOk = 1'b1;
      COND_NONZERO: condOk = ~aluZero;
      COND_ZERO:    condOk = aluZero;
      default:      condOk = 1'b0;
    endcase
    srcOk = (srcCode <= SRC_BIT);
    ctl.src = srcCode;
    ctl.take = isJump & condOk & srcOk;
    ctl.save = isJump & condOk & srcOk & (|callCode);
  end
endmodule

// File: rtl/useq_dpath.sv
module useq_dpath
  import useq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OPC_W,
  parameter int BW = BITSEL_W,
  parameter int NW = NIB_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqCtl_t       ctl,
  input  logic [AW-1:0] imm,
  input  logic [OW-1:0] opcodeByte,
  input  logic [BW-1:0] bitSel,
  output logic [AW-1:0] uAddr,
  output logic [AW-1:0] retAddr
);
  logic [AW-1:0] seqAddr;
  logic [AW-1:0] target;
  logic [AW-1:0] nextAddr;

  always_comb begin
    seqAddr = uAddr + {{(AW-1){1'b0}}, 1'b1};
    case (ctl.src)
      SRC_IMM: target = imm;
      SRC_OPC: target = {{(AW-OW){1'b0}}, opcodeByte};
      SRC_MIX: target = {imm[AW-1:NW], opcodeByte[NW-1:0]};
      SRC_RET: target = retAddr;
      SRC_BIT: target = {{(AW-BW){1'b0}}, bitSel};
      default: target = seqAddr;
    endcase
    nextAddr = ctl.take ? target : seqAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      uAddr <= '0;
      retAddr <= '0;
    end else begin
      uAddr <= nextAddr;
      if (ctl.save) retAddr <= seqAddr;
    end
  end
endmodule

// File: rtl/useq_seq.sv
module useq_seq
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       uinstr,
  input  logic [OPC_W-1:0]  opcodeByte,
  input  logic [RET_W-1:0]  busRetData,
  input  logic              aluZero,
  output logic [ADDR_W-1:0] uAddr,
  output logic [ADDR_W-1:0] retAddr
);
  seqCtl_t ctl;
  logic unusedBits;

  assign unusedBits = ^{uinstr[23], uinstr[15:ADDR_W], busRetData[RET_W-1:BITSEL_W]};

  useq_ctrl u_ctrl (
    .classCode(uinstr[31:28]),
    .callCode (uinstr[27:24]),
    .srcCode  (uinstr[22:20]),
    .condCode (uinstr[19:16]),
    .aluZero  (aluZero),
    .ctl      (ctl)
  );

  useq_dpath #(
    .AW(ADDR_W), .OW(OPC_W), .BW(BITSEL_W), .NW(NIB_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .imm       (uinstr[ADDR_W-1:0]),
    .opcodeByte(opcodeByte),
    .bitSel    (busRetData[BITSEL_W-1:0]),
    .uAddr     (uAddr),
    .retAddr   (retAddr)
  );
endmodule

// File: rtl/useq_chk.sv
module useq_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] uinstr,
  input logic        aluZero,
  input logic [12:0] uAddr,
  input logic [12:0] retAddr
);
  logic isJump;
  logic isCall;
  assign isJump = (uinstr[31:28] == 4'h1);
  assign isCall = |uinstr[27:24];

  // R9
  a_r9_reset_clears: assert property (@(posedge clk)
    !rstN |=> (uAddr == 13'd0 && retAddr == 13'd0));

  // R1
  a_r1_step_on_nonjump: assert property (@(posedge clk) disable iff (!rstN)
    !isJump |=> uAddr == $past(uAddr) + 13'd1);

  // R3
  a_r3_bad_cond_falls_through: assert property (@(posedge clk) disable iff (!rstN)
    (isJump && uinstr[19:16] > 4'd2) |=> uAddr == $past(uAddr) + 13'd1);

  // R6
  a_r6_return_target: assert property (@(posedge clk) disable iff (!rstN)
    (isJump && uinstr[22:20] == 3'd3 && uinstr[19:16] == 4'd0) |=> uAddr == $past(retAddr));

  // R7
  a_r7_call_saves_next: assert property (@(posedge clk) disable iff (!rstN)
    (isJump && isCall && uinstr[22:20] == 3'd0 && uinstr[19:16] == 4'd0)
      |=> retAddr == $past(uAddr) + 13'd1);

  // R7
  a_r7_ret_held_without_call: assert property (@(posedge clk) disable iff (!rstN)
    !(isJump && isCall) |=> $stable(retAddr));

  // R8
  a_r8_bad_src_no_save: assert property (@(posedge clk) disable iff (!rstN)
    (isJump && uinstr[22:20] > 3'd4) |=> ($stable(retAddr) && uAddr == $past(uAddr) + 13'd1));

  // R3
  a_r3_zero_cond_skips: assert property (@(posedge clk) disable iff (!rstN)
    (isJump && uinstr[19:16] == 4'd2 && !aluZero) |=> uAddr == $past(uAddr) + 13'd1);
endmodule

bind useq_seq useq_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .uinstr (uinstr),
  .aluZero(aluZero),
  .uAddr  (uAddr),
  .retAddr(retAddr)
);

// File: tb/tb_useq_seq.sv
module tb_useq_seq;
  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] uinstr;
  logic [7:0]  opcodeByte;
  logic [7:0]  busRetData;
  logic        aluZero;
  logic [12:0] uAddr;
  logic [12:0] retAddr;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  useq_seq dut (
    .clk(clk), .rstN(rstN), .uinstr(uinstr), .opcodeByte(opcodeByte),
    .busRetData(busRetData), .aluZero(aluZero), .uAddr(uAddr), .retAddr(retAddr)
  );

  // jump encoding: 32'h1 C S D IIII  (class, call, source, condition, immediate)
  // vector fields: uinstr, opcode, bus data, aluZero, expected uAddr, expected retAddr
  localparam int NV = 21;
  localparam logic [74:0] VEC [NV] = '{
    {32'h0000_0000, 8'h00, 8'h00, 1'b0, 13'h0001, 13'h0000},
    {32'h2100_0050, 8'h00, 8'h00, 1'b0, 13'h0002, 13'h0000},
    {32'h1000_0100, 8'h00, 8'h00, 1'b0, 13'h0100, 13'h0000},
    {32'h1001_0200, 8'h00, 8'h00, 1'b1, 13'h0101, 13'h0000},
    {32'h1001_0200, 8'h00, 8'h00, 1'b0, 13'h0200, 13'h0000},
    {32'h1002_0300, 8'h00, 8'h00, 1'b0, 13'h0201, 13'h0000},
    {32'h1002_0300, 8'h00, 8'h00, 1'b1, 13'h0300, 13'h0000},
    {32'h1005_0400, 8'h00, 8'h00, 1'b0, 13'h0301, 13'h0000},
    {32'h1010_1FFF, 8'hA7, 8'h00, 1'b0, 13'h00A7, 13'h0000},
    {32'h1020_1234, 8'h5C, 8'h00, 1'b0, 13'h123C, 13'h0000},
    {32'h1100_0800, 8'h00, 8'h00, 1'b0, 13'h0800, 13'h123D},
    {32'h0000_0000, 8'h00, 8'h00, 1'b0, 13'h0801, 13'h123D},
    {32'h1040_0000, 8'h00, 8'hFE, 1'b0, 13'h0006, 13'h123D},
    {32'h1030_0000, 8'h00, 8'h00, 1'b0, 13'h123D, 13'h123D},
    {32'h1F01_0500, 8'h00, 8'h00, 1'b1, 13'h123E, 13'h123D},
    {32'h1F01_1FFF, 8'h00, 8'h00, 1'b0, 13'h1FFF, 13'h123F},
    {32'h0000_0000, 8'h00, 8'h00, 1'b0, 13'h0000, 13'h123F},
    {32'h1130_0000, 8'h00, 8'h00, 1'b0, 13'h123F, 13'h0001},
    {32'h1210_0000, 8'h33, 8'h00, 1'b0, 13'h0033, 13'h1240},
    {32'h1150_0700, 8'h00, 8'h00, 1'b0, 13'h0034, 13'h1240},
    {32'h1010_0000, 8'hFF, 8'h00, 1'b0, 13'h00FF, 13'h1240}
  };
  string reqTag [NV] = '{
    "R1", "R2", "R4", "R3", "R3", "R3", "R3", "R3", "R4", "R4",
    "R7", "R1", "R5", "R6", "R7", "R7", "R1", "R7", "R7", "R8", "R4"
  };

  task automatic check(input string tag, input string what,
                       input logic [12:0] act, input logic [12:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    rstN = 1'b0;
    uinstr = '0;
    opcodeByte = '0;
    busRetData = '0;
    aluZero = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "reset uAddr", uAddr, 13'h0000);
    check("R9", "reset retAddr", retAddr, 13'h0000);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      uinstr = VEC[i][74:43];
      opcodeByte = VEC[i][42:35];
      busRetData = VEC[i][34:27];
      aluZero = VEC[i][26];
      @(negedge clk);
      check(reqTag[i], $sformatf("vec %0d uAddr", i), uAddr, VEC[i][25:13]);
      check(reqTag[i], $sformatf("vec %0d retAddr", i), retAddr, VEC[i][12:0]);
    end
    // R9: reset wins over a taken call issued in the same cycle
    rstN = 1'b0;
    uinstr = 32'h1100_0555;
    @(negedge clk);
    check("R9", "mid-run reset uAddr", uAddr, 13'h0000);
    check("R9", "mid-run reset retAddr", retAddr, 13'h0000);
    rstN = 1'b1;
    uinstr = 32'h3000_0000;
    @(negedge clk);
    check("R1", "step after reset", uAddr, 13'h0001);
    check("R7", "ret kept after non-jump", retAddr, 13'h0000);
    finish_run();
  end

  initial begin
    #2_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule